// File: doc/BRIEF.md
# Latched Fault Status with Interrupt

This block gathers per-channel health flags for three kinds of fault (output signal present, reference present, wrap-around accuracy good) and presents them as three status registers. A bit reads 1 when the channel is healthy and 0 when it has failed. A mask of active channels forces unused channels to read healthy, so that unconnected channels never raise false alarms. When a healthy bit turns to failed, its register latches, freezing the fault pattern for software. The block then raises a prioritised interrupt request on one of seven request lines, chosen by a programmable level, and it answers the acknowledge cycle with a programmable vector.

Software reads a latched register to release it. While the register is frozen, the live fault pattern keeps being copied into a background shadow. A fixed number of clock cycles after the read, the shadow is moved into the visible register. A fault that arrived or cleared while the register was frozen therefore becomes visible without a second read. If the moved-in pattern holds a new fault, the register latches again and a new interrupt is requested. After each acknowledge, the next error raises a fresh request. The fault measurement itself and the bus protocol timing are handled elsewhere. This block sees only the health flags, a read strobe with a register select, and an acknowledge strobe with a level.

Top module: `fault_stat_irq`

## Requirements
- R1: After reset all three status registers read all ones, every request line is low, `vecValid` is 0 and `vecOut` is 0.
- R2: A register that is not latched takes the masked health inputs on the next clock edge (1 = healthy, 0 = failed). `sigOk`, `refOk` and `accOk` feed `sigStatus`, `refStatus` and `accStatus`.
- R3: A channel whose `activeMask` bit is 0 reads 1 in all three registers and can never cause a latch or an interrupt.
- R4: When a bit that reads 1 in an unlatched register sees a failed input, the register latches on that edge. It then holds its value while inputs keep changing.
- R5: A read is one cycle of `rdStrobe` with `rdSel` selecting the register: 0 = signal, 1 = reference, 2 = accuracy, 3 = none. It releases only the selected register, and a read of a register that is not latched has no effect.
- R6: While a register is latched or waiting after a read, the live masked inputs are copied into a shadow. `HOLD_CYCLES` edges after the read edge, the register takes the shadow value, which is the masked inputs of the cycle before. From then on it follows the inputs again.
- R7: If the pattern moved in from the shadow contains a bit that fails where the register read 1, the register latches again and an error is signalled.
- R8: An error with `intLevel` from 1 to 7 drives exactly request line `irqLines[intLevel-1]` from the next edge. With `intLevel` 0 no line rises. At most one line is ever high.
- R9: A request stays high until an acknowledge: `iackIn` high with `iackLevel` equal to the pending level. On the edge after that cycle the line drops, `vecValid` is high for that cycle, and `vecOut` carries `intVector`. At all other times `vecOut` is 0.
- R10: Errors while a request is pending add no second request. An error after an acknowledge raises a fresh request. An error on the acknowledge edge keeps the request raised.
- R11: An acknowledge whose level differs from the pending level, or one that arrives with no request pending, changes no line and gives no vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sigOk | input | NUM_CH | Per-channel output-signal health, 1 = healthy |
| refOk | input | NUM_CH | Per-channel reference health, 1 = healthy |
| accOk | input | NUM_CH | Per-channel accuracy health, 1 = healthy |
| activeMask | input | NUM_CH | 1 = channel is monitored |
| intLevel | input | 3 | Request level, 0 = interrupts off |
| intVector | input | VEC_W | Vector returned on acknowledge |
| rdStrobe | input | 1 | One-cycle status read |
| rdSel | input | 2 | Register being read (0 signal, 1 reference, 2 accuracy) |
| iackIn | input | 1 | Acknowledge strobe |
| iackLevel | input | 3 | Level being acknowledged |
| sigStatus | output | NUM_CH | Signal status register |
| refStatus | output | NUM_CH | Reference status register |
| accStatus | output | NUM_CH | Accuracy status register |
| irqLines | output | 7 | Request lines, bit n = level n+1 |
| vecOut | output | VEC_W | Vector during the acknowledge response, else 0 |
| vecValid | output | 1 | High for one cycle after an accepted acknowledge |

## Verification
Suppose a register's hold state is wrong, for example it never leaves the latch or moves the shadow in too early. The status output then differs from the reference model on the first clock after the hold window should have ended, and the release timing is checked edge by edge around that point. A wrong pending flag or a wrongly captured level shows up on the request lines in the cycle after the error or the acknowledge. A lost or repeated acknowledge shows up on `vecValid` and `vecOut` one cycle after the strobe. Because every output is compared with the model on every clock, any such divergence is reported in the cycle it first reaches a port.

// File: rtl/fault_stat_pkg.sv
package fault_stat_pkg;
  localparam int NUM_REGS  = 3;
  localparam int LVL_W     = 3;
  localparam int NUM_LINES = (1 << LVL_W) - 1;
  localparam int SEL_W     = 2;

  localparam logic [SEL_W-1:0] SEL_SIG = 2'd0;
  localparam logic [SEL_W-1:0] SEL_REF = 2'd1;
  localparam logic [SEL_W-1:0] SEL_ACC = 2'd2;

  typedef enum logic [1:0] {
    REG_FREE    = 2'd0,
    REG_LATCHED = 2'd1,
    REG_HOLD    = 2'd2
  } regState_e;

  typedef struct packed {
    logic [NUM_REGS-1:0] loadLive;
    logic [NUM_REGS-1:0] loadShadow;
    logic [NUM_REGS-1:0] trackShadow;
  } dpStrobe_t;
endpackage

// File: rtl/fault_stat_dp.sv
module fault_stat_dp
  import fault_stat_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_CH-1:0]   sigOk,
  input  logic [NUM_CH-1:0]   refOk,
  input  logic [NUM_CH-1:0]   accOk,
  input  logic [NUM_CH-1:0]   activeMask,
  input  dpStrobe_t           strobe,
  output logic [NUM_CH-1:0]   sigStatus,
  output logic [NUM_CH-1:0]   refStatus,
  output logic [NUM_CH-1:0]   accStatus,
  output logic [NUM_REGS-1:0] liveFault,
  output logic [NUM_REGS-1:0] shadowFault
);
  logic [NUM_REGS-1:0][NUM_CH-1:0] rawOk;
  logic [NUM_REGS-1:0][NUM_CH-1:0] effOk;
  logic [NUM_REGS-1:0][NUM_CH-1:0] statVis;

  assign rawOk[0] = sigOk;
  assign rawOk[1] = refOk;
  assign rawOk[2] = accOk;

  generate
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
      logic [NUM_CH-1:0] statQ;
      logic [NUM_CH-1:0] shadowQ;

      // inactive channels are forced healthy before anything sees them
      assign effOk[g]       = rawOk[g] | ~activeMask;
      assign liveFault[g]   = |(statQ & ~effOk[g]);
      assign shadowFault[g] = |(statQ & ~shadowQ);
      assign statVis[g]     = statQ;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          statQ   <= '1;
          shadowQ <= '1;
        end else begin
          if (strobe.loadShadow[g]) begin
            statQ <= shadowQ;
          end else if (strobe.loadLive[g]) begin
            statQ <= effOk[g];
          end
          if (strobe.trackShadow[g]) begin
            shadowQ <= effOk[g];
          end
        end
      end
    end
  endgenerate

  assign sigStatus = statVis[0];
  assign refStatus = statVis[1];
  assign accStatus = statVis[2];
endmodule

// File: rtl/fault_stat_ctrl.sv
module fault_stat_ctrl
  import fault_stat_pkg::*;
#(
  parameter int HOLD_CYCLES = 12_500_000,
  parameter int VEC_W       = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 rdStrobe,
  input  logic [SEL_W-1:0]     rdSel,
  input  logic [NUM_REGS-1:0]  liveFault,
  input  logic [NUM_REGS-1:0]  shadowFault,
  input  logic [LVL_W-1:0]     intLevel,
  input  logic [VEC_W-1:0]     intVector,
  input  logic                 iackIn,
  input  logic [LVL_W-1:0]     iackLevel,
  output dpStrobe_t            strobe,
  output logic [NUM_LINES-1:0] irqLines,
  output logic [VEC_W-1:0]     vecOut,
  output logic                 vecValid
);
  localparam int CNT_W = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(HOLD_CYCLES - 1);

  logic [NUM_REGS-1:0] loadLive;
  logic [NUM_REGS-1:0] loadShadow;
  logic [NUM_REGS-1:0] trackShadow;
  logic [NUM_REGS-1:0] errEvt;

  generate
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_seq
      regState_e        state;
      logic [CNT_W-1:0] holdCnt;
      logic             readHit;
      logic             expire;

      assign readHit        = rdStrobe && (rdSel == SEL_W'(g));
      assign expire         = (state == REG_HOLD) && (holdCnt == '0);
      assign loadLive[g]    = (state == REG_FREE);
      assign trackShadow[g] = (state != REG_FREE);
      assign loadShadow[g]  = expire;
      assign errEvt[g]      = ((state == REG_FREE) && liveFault[g])
                            || (expire && shadowFault[g]);

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          state   <= REG_FREE;
          holdCnt <= '0;
        end else begin
          unique case (state)
            REG_FREE: begin
              if (liveFault[g]) state <= REG_LATCHED;
            end
            REG_LATCHED: begin
              if (readHit) begin
                state   <= REG_HOLD;
                holdCnt <= CNT_LOAD;
              end
            end
            REG_HOLD: begin
              if (holdCnt == '0) begin
                state <= shadowFault[g] ? REG_LATCHED : REG_FREE;
              end else begin
                holdCnt <= holdCnt - 1'b1;
              end
            end
            default: state <= REG_FREE;
          endcase
        end
      end
    end
  endgenerate

  assign strobe = {loadLive, loadShadow, trackShadow};

  // interrupt request / acknowledge
  logic             pending;
  logic [LVL_W-1:0] reqLevel;
  logic             raise;
  logic             ackHit;

  assign raise  = (|errEvt) && (intLevel != '0);
  assign ackHit = pending && iackIn && (iackLevel == reqLevel);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending  <= 1'b0;
      reqLevel <= '0;
      vecValid <= 1'b0;
      vecOut   <= '0;
    end else begin
      pending <= (pending && !ackHit) || raise;
      if (raise && (!pending || ackHit)) begin
        reqLevel <= intLevel;
      end
      vecValid <= ackHit;
      vecOut   <= ackHit ? intVector : '0;
    end
  end

  generate
    for (genvar l = 1; l <= NUM_LINES; l++) begin : g_line
      assign irqLines[l-1] = pending && (reqLevel == LVL_W'(l));
    end
  endgenerate
endmodule

// File: rtl/fault_stat_irq.sv
module fault_stat_irq
  import fault_stat_pkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int HOLD_CYCLES = 12_500_000,
  parameter int VEC_W       = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_CH-1:0]    sigOk,
  input  logic [NUM_CH-1:0]    refOk,
  input  logic [NUM_CH-1:0]    accOk,
  input  logic [NUM_CH-1:0]    activeMask,
  input  logic [LVL_W-1:0]     intLevel,
  input  logic [VEC_W-1:0]     intVector,
  input  logic                 rdStrobe,
  input  logic [SEL_W-1:0]     rdSel,
  input  logic                 iackIn,
  input  logic [LVL_W-1:0]     iackLevel,
  output logic [NUM_CH-1:0]    sigStatus,
  output logic [NUM_CH-1:0]    refStatus,
  output logic [NUM_CH-1:0]    accStatus,
  output logic [NUM_LINES-1:0] irqLines,
  output logic [VEC_W-1:0]     vecOut,
  output logic                 vecValid
);
  dpStrobe_t           strobe;
  logic [NUM_REGS-1:0] liveFault;
  logic [NUM_REGS-1:0] shadowFault;

  fault_stat_dp #(.NUM_CH(NUM_CH)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .sigOk      (sigOk),
    .refOk      (refOk),
    .accOk      (accOk),
    .activeMask (activeMask),
    .strobe     (strobe),
    .sigStatus  (sigStatus),
    .refStatus  (refStatus),
    .accStatus  (accStatus),
    .liveFault  (liveFault),
    .shadowFault(shadowFault)
  );

  fault_stat_ctrl #(.HOLD_CYCLES(HOLD_CYCLES), .VEC_W(VEC_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .rdStrobe   (rdStrobe),
    .rdSel      (rdSel),
    .liveFault  (liveFault),
    .shadowFault(shadowFault),
    .intLevel   (intLevel),
    .intVector  (intVector),
    .iackIn     (iackIn),
    .iackLevel  (iackLevel),
    .strobe     (strobe),
    .irqLines   (irqLines),
    .vecOut     (vecOut),
    .vecValid   (vecValid)
  );
endmodule

// File: rtl/fault_stat_irq_chk.sv
module fault_stat_irq_chk
  import fault_stat_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [LVL_W-1:0]     intLevel,
  input logic                 iackIn,
  input logic [NUM_LINES-1:0] irqLines,
  input logic [VEC_W-1:0]     vecOut,
  input logic                 vecValid
);
  // R8: never more than one request line
  p_onehot_lines_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(irqLines));

  // R8: a line only rises after an error seen with a nonzero level
  p_raise_level_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(|irqLines) |-> ($past(intLevel) != '0));

  // R9: without an acknowledge strobe a raised line is held
  p_lines_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    ((|irqLines) && !iackIn) |=> (irqLines == $past(irqLines)));

  // R9: a vector only follows an acknowledge strobe
  p_vec_after_ack_r9: assert property (@(posedge clk) disable iff (!rstN)
    vecValid |-> $past(iackIn));

  // R9: the vector bus is quiet outside the response cycle
  p_vec_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    !vecValid |-> (vecOut == '0));

  // R11: a request ends only with an accepted acknowledge
  p_drop_by_ack_r11: assert property (@(posedge clk) disable iff (!rstN)
    $fell(|irqLines) |-> vecValid);
endmodule

bind fault_stat_irq fault_stat_irq_chk #(.VEC_W(VEC_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .intLevel(intLevel),
  .iackIn  (iackIn),
  .irqLines(irqLines),
  .vecOut  (vecOut),
  .vecValid(vecValid)
);

// File: tb/fault_stat_irq_bench.sv
module fault_stat_irq_bench;
  localparam int NCH  = 4;
  localparam int HOLD = 6;
  localparam int VW   = 8;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic [NCH-1:0] sigOk = '1, refOk = '1, accOk = '1, activeMask = '1;
  logic [2:0]     intLevel = '0;
  logic [VW-1:0]  intVector = '0;
  logic           rdStrobe = 1'b0;
  logic [1:0]     rdSel = 2'd3;
  logic           iackIn = 1'b0;
  logic [2:0]     iackLevel = '0;
  logic [NCH-1:0] sigStatus, refStatus, accStatus;
  logic [6:0]     irqLines;
  logic [VW-1:0]  vecOut;
  logic           vecValid;

  int  nCmp = 0;
  int  nBad = 0;
  bit  done = 0;

  always #10 clk = ~clk;

  fault_stat_irq #(.NUM_CH(NCH), .HOLD_CYCLES(HOLD), .VEC_W(VW)) u_fault_stat_irq (
    .clk(clk), .rstN(rstN), .sigOk(sigOk), .refOk(refOk), .accOk(accOk),
    .activeMask(activeMask), .intLevel(intLevel), .intVector(intVector),
    .rdStrobe(rdStrobe), .rdSel(rdSel), .iackIn(iackIn), .iackLevel(iackLevel),
    .sigStatus(sigStatus), .refStatus(refStatus), .accStatus(accStatus),
    .irqLines(irqLines), .vecOut(vecOut), .vecValid(vecValid)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nCmp++;
    if (got !== exp) begin
      nBad++;
      $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // behavioural reference model: mode 0 follows, 1 frozen, 2 waiting after read
  logic [NCH-1:0] mStat[3];
  logic [NCH-1:0] mShad[3];
  int             mMode[3];
  int             mWait[3];
  logic           mPend;
  logic [2:0]     mLvl;
  logic [VW-1:0]  mVec;
  logic           mVld;

  always @(posedge clk) begin
    logic [NCH-1:0] eff[3];
    logic [NCH-1:0] prev;
    logic err, ack, raise;
    if (!rstN) begin
      for (int r = 0; r < 3; r++) begin
        mStat[r] = '1; mShad[r] = '1; mMode[r] = 0; mWait[r] = 0;
      end
      mPend = 0; mLvl = 0; mVec = 0; mVld = 0;
    end else begin
      eff[0] = sigOk | ~activeMask;
      eff[1] = refOk | ~activeMask;
      eff[2] = accOk | ~activeMask;
      err = 0;
      ack = mPend && iackIn && (iackLevel == mLvl);
      for (int r = 0; r < 3; r++) begin
        if (mMode[r] == 0) begin
          if ((mStat[r] & ~eff[r]) != 0) begin mMode[r] = 1; err = 1; end
          mStat[r] = eff[r];
        end else begin
          prev = mShad[r];
          if (mMode[r] == 1) begin
            if (rdStrobe && (int'(rdSel) == r)) begin mMode[r] = 2; mWait[r] = HOLD - 1; end
          end else if (mWait[r] == 0) begin
            if ((mStat[r] & ~prev) != 0) begin mMode[r] = 1; err = 1; end
            else mMode[r] = 0;
            mStat[r] = prev;
          end else begin
            mWait[r] = mWait[r] - 1;
          end
          mShad[r] = eff[r];
        end
      end
      raise = err && (intLevel != 0);
      if (raise && (!mPend || ack)) mLvl = intLevel;
      mPend = (mPend && !ack) || raise;
      mVld  = ack;
      mVec  = ack ? intVector : '0;
    end
  end

  // compare every output with the model on every cycle
  always @(negedge clk) begin
    if (rstN) begin
      chk("R2/R4/R6 sigStatus vs model", sigStatus, mStat[0]);
      chk("R2/R4/R6 refStatus vs model", refStatus, mStat[1]);
      chk("R2/R4/R6 accStatus vs model", accStatus, mStat[2]);
      chk("R8/R10 irqLines vs model", irqLines, mPend ? (7'b1 << (mLvl - 1)) : 7'b0);
      chk("R9 vecValid vs model", vecValid, mVld);
      chk("R9 vecOut vs model", vecOut, mVec);
    end
  end

  task automatic doRead(input logic [1:0] sel);
    rdStrobe = 1'b1; rdSel = sel;
    tick(1);
    rdStrobe = 1'b0; rdSel = 2'd3;
  endtask

  task automatic doAck(input logic [2:0] lvl);
    iackIn = 1'b1; iackLevel = lvl;
    tick(1);
    iackIn = 1'b0;
  endtask

  initial begin
    tick(3);
    rstN = 1'b1;
    tick(1);
    chk("R1 reset sigStatus", sigStatus, 4'hF);
    chk("R1 reset refStatus", refStatus, 4'hF);
    chk("R1 reset accStatus", accStatus, 4'hF);
    chk("R1 reset irqLines", irqLines, 0);
    chk("R1 reset vecValid", vecValid, 0);

    intLevel = 3'd3; intVector = 8'hA5; activeMask = 4'b1011;
    tick(1);
    refOk = 4'b1011;  // fault on inactive channel 2
    tick(3);
    chk("R3 inactive fault hidden", refStatus, 4'hF);
    chk("R3 inactive fault no irq", irqLines, 0);

    sigOk = 4'b1101;
    tick(1);
    chk("R2 sigStatus shows fault", sigStatus, 4'b1101);
    chk("R8 level 3 line", irqLines, 7'b0000100);
    sigOk = 4'hF;
    tick(3);
    chk("R4 latched register frozen", sigStatus, 4'b1101);

    doRead(2'd1);
    tick(HOLD + 2);
    chk("R5 other register stays latched", sigStatus, 4'b1101);
    chk("R5 read of free register no effect", refStatus, 4'hF);

    doAck(3'd2);
    chk("R11 wrong level no vector", vecValid, 0);
    tick(1);
    chk("R11 wrong level keeps line", irqLines, 7'b0000100);

    doAck(3'd3);
    chk("R9 vector valid", vecValid, 1);
    chk("R9 vector value", vecOut, 8'hA5);
    chk("R9 line dropped", irqLines, 0);
    tick(1);
    chk("R9 single vector cycle", vecValid, 0);

    doRead(2'd0);
    tick(HOLD - 1);
    chk("R6 still frozen before window end", sigStatus, 4'b1101);
    tick(1);
    chk("R6 background value applied", sigStatus, 4'hF);
    chk("R6 no relatch on recovery", irqLines, 0);

    accOk = 4'b1110;
    tick(1);
    chk("R10 fresh request after ack", irqLines, 7'b0000100);
    doAck(3'd3);
    doRead(2'd2);
    accOk = 4'b0111;
    tick(HOLD - 1);
    chk("R7 frozen during wait", accStatus, 4'b1110);
    tick(1);
    chk("R7 shadow pattern applied", accStatus, 4'b0111);
    chk("R7 new fault re-requests", irqLines, 7'b0000100);

    sigOk = 4'b0111;
    tick(1);
    chk("R10 no second request while pending", irqLines, 7'b0000100);
    doAck(3'd3);
    tick(1);
    chk("R10 one ack clears all", irqLines, 0);

    intLevel = 3'd0;
    refOk = 4'b0011;
    tick(1);
    chk("R3/R8 masked pattern", refStatus, 4'b0111);
    chk("R8 level 0 no line", irqLines, 0);

    doAck(3'd0);
    chk("R11 ack with nothing pending", vecValid, 0);

    for (int i = 0; i < 6000; i++) begin
      if ($urandom % 6 == 0) sigOk = NCH'($urandom);
      if ($urandom % 6 == 0) refOk = NCH'($urandom);
      if ($urandom % 6 == 0) accOk = NCH'($urandom);
      if ($urandom % 2 == 0) begin sigOk = '1; refOk = '1; accOk = '1; end
      if ($urandom % 97 == 0) activeMask = NCH'($urandom);
      if ($urandom % 53 == 0) intLevel = 3'($urandom);
      if ($urandom % 29 == 0) intVector = VW'($urandom);
      rdStrobe  = ($urandom % 4 == 0);
      rdSel     = 2'($urandom);
      iackIn    = ($urandom % 5 == 0);
      iackLevel = 3'($urandom);
      tick(1);
    end
    rdStrobe = 0; iackIn = 0;
    tick(2);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog R1: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end
endmodule